// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit binary adder. It adds two operands and a carry-in, and it returns the sum, the carry-out, and a generate/propagate pair that covers the whole word. A wider lookahead tree can use that pair one level up.

The datapath is split into groups of four bits. Inside each group, every bit position forms a generate term (a AND b) and a propagate term (a OR b). A lookahead unit turns these terms into the carry into each bit without a ripple chain. Each group also reduces its terms to one group generate and one group propagate. A second lookahead unit of the same form takes those four pairs and the external carry-in. It produces the carry into every group and the overall generate and propagate. No carry ripples from one group into the next.

Width and group size are parameters. The default is four groups of four bits.

Top module: `cla16_adder`

## Requirements
- R1: For every input combination, the 17-bit value {cout_o, sum_o} equals a_i + b_i + cin_i taken as unsigned numbers.
- R2: With a_i = 0 and b_i = 0, cin_i = 1 yields sum_o = 16'h0001 and cout_o = 0, and cin_i = 0 yields all outputs at zero.
- R3: A carry entering at bit 0 travels through every bit. a_i = 16'hFFFF, b_i = 0, cin_i = 1 yields sum_o = 0 and cout_o = 1. a_i = 16'hFFFF, b_i = 16'h0001, cin_i = 0 gives the same result.
- R4: grp_p_o is 1 exactly when every bit position has a_i[k] OR b_i[k] set.
- R5: grp_g_o is 1 exactly when a_i + b_i, with no carry-in, carries out of bit 15.
- R6: cout_o equals grp_g_o OR (grp_p_o AND cin_i).
- R7: A carry crosses each group boundary (after bits 3, 7 and 11). Adding 1 to 16'h000F, 16'h00FF and 16'h0FFF gives 16'h0010, 16'h0100 and 16'h1000, each with cout_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First addend |
| b_i | input | 16 | Second addend |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| grp_g_o | output | 1 | Word-level generate |
| grp_p_o | output | 1 | Word-level propagate |

## Verification
Two effects can land in the same evaluation: a carry that the second-level unit forwards into a group, and a carry that the group's own lookahead creates at one of its bits. When both occur, each sum bit must see the correct combined carry. The bench provokes this in two ways. First, it sweeps the low five bits of both operands exhaustively, which straddles the first group boundary, while the upper bits are random. Second, it applies directed vectors that chain propagates across whole groups. Each sum, carry-out and word-level generate/propagate value is judged against an independent behavioural addition done in the bench.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned DEF_WIDTH   = 16;
  localparam int unsigned DEF_GROUP_W = 4;
endpackage

// File: rtl/cla_unit.sv
// Generic lookahead unit: carries into each of W positions plus block G/P,
// every term written as a flat sum of products (no ripple form).
module cla_unit #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  input  logic         c_i,
  output logic [W-1:0] carry_o,
  output logic         grp_g_o,
  output logic         grp_p_o
);
  logic acc;
  logic prod;

  always_comb begin
    carry_o = '0;
    for (int j = 0; j < W; j++) begin
      prod = c_i;
      for (int k = 0; k < j; k++) prod = prod & p_i[k];
      acc = prod;
      for (int i = 0; i < j; i++) begin
        prod = g_i[i];
        for (int k = i + 1; k < j; k++) prod = prod & p_i[k];
        acc = acc | prod;
      end
      carry_o[j] = acc;
    end
  end

  always_comb begin
    grp_g_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      logic term;
      term = g_i[i];
      for (int k = i + 1; k < W; k++) term = term & p_i[k];
      grp_g_o = grp_g_o | term;
    end
  end

  assign grp_p_o = &p_i;
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         grp_g_o,
  output logic         grp_p_o
);
  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W-1:0] bit_c;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i | b_i;

  cla_unit #(.W(W)) u_la (
    .g_i     (bit_g),
    .p_i     (bit_p),
    .c_i     (c_i),
    .carry_o (bit_c),
    .grp_g_o (grp_g_o),
    .grp_p_o (grp_p_o)
  );

  assign sum_o = a_i ^ b_i ^ bit_c;
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int unsigned WIDTH   = cla_pkg::DEF_WIDTH,
  parameter int unsigned GROUP_W = cla_pkg::DEF_GROUP_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             grp_g_o,
  output logic             grp_p_o
);
  localparam int unsigned N_GROUPS = WIDTH / GROUP_W;

  logic [N_GROUPS-1:0] lvl1_g;
  logic [N_GROUPS-1:0] lvl1_p;
  logic [N_GROUPS-1:0] lvl1_c;
  logic                top_g;
  logic                top_p;

  for (genvar gi = 0; gi < N_GROUPS; gi++) begin : g_grp
    cla_group #(.W(GROUP_W)) u_grp (
      .a_i     (a_i[gi*GROUP_W +: GROUP_W]),
      .b_i     (b_i[gi*GROUP_W +: GROUP_W]),
      .c_i     (lvl1_c[gi]),
      .sum_o   (sum_o[gi*GROUP_W +: GROUP_W]),
      .grp_g_o (lvl1_g[gi]),
      .grp_p_o (lvl1_p[gi])
    );
  end

  // Second level: group carries from group G/P and the external carry-in
  cla_unit #(.W(N_GROUPS)) u_lvl2 (
    .g_i     (lvl1_g),
    .p_i     (lvl1_p),
    .c_i     (cin_i),
    .carry_o (lvl1_c),
    .grp_g_o (top_g),
    .grp_p_o (top_p)
  );

  assign cout_o  = top_g | (top_p & cin_i);
  assign grp_g_o = top_g;
  assign grp_p_o = top_p;
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
  parameter int unsigned WIDTH   = cla_pkg::DEF_WIDTH,
  parameter int unsigned GROUP_W = cla_pkg::DEF_GROUP_W
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             grp_g_o,
  input logic             grp_p_o
);
  logic [WIDTH:0] ref_full;
  logic [WIDTH:0] ref_nocin;

  always_comb begin
    ref_full  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    ref_nocin = {1'b0, a_i} + {1'b0, b_i};
  end

  always_comb begin
    a_r1_sum_matches: assert ({cout_o, sum_o} == ref_full)
      else $error("R1 sum mismatch");
    a_r4_word_propagate: assert (grp_p_o == &(a_i | b_i))
      else $error("R4 propagate mismatch");
    a_r5_word_generate: assert (grp_g_o == ref_nocin[WIDTH])
      else $error("R5 generate mismatch");
    a_r6_cout_from_gp: assert (cout_o == (grp_g_o | (grp_p_o & cin_i)))
      else $error("R6 carry-out mismatch");
  end
endmodule

bind cla16_adder cla16_adder_chk #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .grp_g_o (grp_g_o),
  .grp_p_o (grp_p_o)
);

// File: tb/cla16_adder_bench.sv
`timescale 1ns/1ps
module cla16_adder_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;
  logic        gg;
  logic        gp;

  int unsigned n_vec  = 0;
  int unsigned n_fail = 0;
  int unsigned cyc    = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cla16_adder u_cla16_adder (
    .a_i     (a),
    .b_i     (b),
    .cin_i   (cin),
    .sum_o   (sum),
    .cout_o  (cout),
    .grp_g_o (gg),
    .grp_p_o (gp)
  );

  function automatic logic [16:0] exp_add(logic [15:0] x, logic [15:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {16'd0, c};
  endfunction
  function automatic logic exp_gen(logic [15:0] x, logic [15:0] y);
    logic [16:0] t;
    t = {1'b0, x} + {1'b0, y};
    return t[16];
  endfunction
  function automatic logic exp_prop(logic [15:0] x, logic [15:0] y);
    return &(x | y);
  endfunction

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c,
                       input string tag);
    logic [16:0] e;
    bit bad;
    @(posedge clk); #1;
    a = x; b = y; cin = c;
    @(negedge clk);
    e = exp_add(x, y, c);
    bad = 1'b0;
    n_vec++;
    if ({cout, sum} != e) begin
      $display("FAIL %s a=%h b=%h cin=%0d: {cout,sum} actual %h expected %h",
               tag, x, y, c, {cout, sum}, e);
      bad = 1'b1;
    end
    if (gp != exp_prop(x, y)) begin
      $display("FAIL R4 a=%h b=%h: grp_p actual %0d expected %0d", x, y, gp, exp_prop(x, y));
      bad = 1'b1;
    end
    if (gg != exp_gen(x, y)) begin
      $display("FAIL R5 a=%h b=%h: grp_g actual %0d expected %0d", x, y, gg, exp_gen(x, y));
      bad = 1'b1;
    end
    if (cout != (gg | (gp & c))) begin
      $display("FAIL R6 a=%h b=%h cin=%0d: cout actual %0d expected %0d",
               x, y, c, cout, gg | (gp & c));
      bad = 1'b1;
    end
    if (bad) n_fail++;
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // R2: zero operands
    apply(16'h0000, 16'h0000, 1'b0, "R2 zero");
    apply(16'h0000, 16'h0000, 1'b1, "R2 cin only");
    // R3: full propagation
    apply(16'hFFFF, 16'h0000, 1'b1, "R3 ones+cin");
    apply(16'hFFFF, 16'h0001, 1'b0, "R3 ones+1");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R3 ones+ones+cin");
    // R7: group boundary crossings
    apply(16'h000F, 16'h0001, 1'b0, "R7 bnd3");
    apply(16'h00FF, 16'h0001, 1'b0, "R7 bnd7");
    apply(16'h0FFF, 16'h0001, 1'b0, "R7 bnd11");
    apply(16'h0FFF, 16'h0000, 1'b1, "R7 bnd11 cin");
    apply(16'h5555, 16'hAAAA, 1'b1, "R3 alt propagate");
    apply(16'h8000, 16'h8000, 1'b0, "R5 top generate");
    // R1: exhaustive low five bits, random upper bits
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 32; j++) begin
        for (int c = 0; c < 2; c++) begin
          logic [31:0] r;
          r = $urandom;
          apply({r[10:0], i[4:0]}, {r[26:16], j[4:0]}, c[0], "R1 low sweep");
        end
      end
    end
    // R1: random vectors
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r[15:0], r[31:16], r[0] ^ r[17], "R1 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule